// File: doc/BRIEF.md
# Carrier Phase Generator with Buffered Frequency and Offset

This block is the phase generator of a digital down-converter's carrier oscillator. A 32-bit accumulator advances by an active frequency step each time an input sample arrives. The step is the desired carrier frequency divided by the sample rate, scaled by 2^32. Read as a signed number, it covers minus half to plus half of the sample rate. A 10-bit phase offset is added to the top ten bits of the accumulator to form the output phase. That phase then drives a sine/cosine table, which lies outside this block.

Software never writes the active step or the active offset directly. Each value first goes into its own holding register. Nothing changes at the output until a transfer happens. The frequency strobe moves the held step into the active register, and the offset strobe does the same for the offset. An external sync pulse moves both together, so several channels can retune in the same cycle, but only while the sync-enable input is high. The offset can be read as two's complement, covering minus pi to pi, or as offset binary, covering 0 to 2 pi. The block handles both readings the same way, since the sum wraps modulo 2^10.

Top module: `carrier_phase_gen`

## Requirements
- R1: After reset, the holding registers, the active registers and the accumulator are zero, so `phase_out` is 0.
- R2: `freq_wr` loads `freq_wdata` into the frequency holding register only. The accumulator keeps stepping by the previous active value until a transfer occurs.
- R3: When `freq_strobe` is high at a clock edge, the held frequency is copied to the active frequency. Accumulation at that same edge still uses the old step; the new step applies from the next sampled edge.
- R4: When `ofs_strobe` is high at a clock edge, the held offset is copied to the active offset. The new offset appears on `phase_out` right after that edge.
- R5: When `sync_in` and `sync_en` are both high at a clock edge, both held values are copied to their active registers at that edge.
- R6: A `sync_in` pulse while `sync_en` is low leaves both active registers unchanged.
- R7: The accumulator adds the active step only on edges where `sample_vld` is high, and it wraps modulo 2^32. With `sample_vld` low it holds its value.
- R8: `phase_out` equals the top 10 bits of the accumulator (bits 31..22) plus the active offset, modulo 2^10. It is combinational from the registered state.
- R9: If a holding register is written at the same edge as its transfer, the active register takes the holding value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_vld | input | 1 | High on clocks that carry an input sample |
| freq_wr | input | 1 | Load the frequency holding register |
| freq_wdata | input | 32 | Frequency step value |
| ofs_wr | input | 1 | Load the offset holding register |
| ofs_wdata | input | 10 | Phase offset value |
| freq_strobe | input | 1 | Transfer held frequency to active |
| ofs_strobe | input | 1 | Transfer held offset to active |
| sync_in | input | 1 | External sync pulse |
| sync_en | input | 1 | Lets `sync_in` transfer both holding registers |
| phase_out | output | 10 | Offset output phase |

## Verification
The bench targets the following cases:
- A sync pulse with the enable low: a design that ignores the enable would retune early.
- A write to a holding register at the same edge as its strobe: a design that forwards the new data would skip a step of double buffering.
- A strobe on an edge that also accumulates: a design that applied the new step too soon would be off by one step from then on.
- Steps of 0x8000_0000 and all-ones, together with large offsets: a missing wrap in the 32-bit accumulator or in the 10-bit offset sum would leave the phase wrong.

Beyond these cases, the bench sweeps every combination of the seven control inputs with fresh data many times.

// File: rtl/carrier_pkg.sv
package carrier_pkg;
    localparam int unsigned DEF_FREQ_W = 32;
    localparam int unsigned DEF_PH_W   = 10;

    // Source of a holding-to-active transfer
    typedef enum logic [1:0] {
        XFER_NONE   = 2'd0,
        XFER_STROBE = 2'd1,
        XFER_SYNC   = 2'd2
    } xfer_src_e;
endpackage

// File: rtl/dbuf_reg.sv
module dbuf_reg
    import carrier_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         strobe,
    input  logic         sync_xfer,
    output logic [W-1:0] hold_q,
    output logic [W-1:0] act_q
);
    typedef struct packed {
        logic [W-1:0] hold;
        logic [W-1:0] act;
    } state_t;

    state_t    st_d, st_q;
    xfer_src_e src;

    always_comb begin
        if (sync_xfer)   src = XFER_SYNC;
        else if (strobe) src = XFER_STROBE;
        else             src = XFER_NONE;
    end

    always_comb begin
        st_d = st_q;
        if (wr) st_d.hold = wdata;
        // transfer takes the holding value present before this edge
        if (src != XFER_NONE) st_d.act = st_q.hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold_q = st_q.hold;
    assign act_q  = st_q.act;
endmodule

// File: rtl/phase_accum.sv
module phase_accum #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         advance,
    input  logic [W-1:0] step,
    output logic [W-1:0] acc_q
);
    typedef struct packed {
        logic [W-1:0] acc;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (advance) st_d.acc = st_q.acc + step;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_q = st_q.acc;
endmodule

// File: rtl/phase_sum.sv
module phase_sum #(
    parameter int unsigned AW = 32,
    parameter int unsigned PW = 10
) (
    input  logic [AW-1:0] acc,
    input  logic [PW-1:0] ofs,
    output logic [PW-1:0] phase
);
    localparam int unsigned TOP_LSB = AW - PW;

    logic [PW-1:0] coarse;

    always_comb begin
        coarse = acc[AW-1:TOP_LSB];
        phase  = coarse + ofs;
    end
endmodule

// File: rtl/carrier_phase_gen.sv
module carrier_phase_gen
    import carrier_pkg::*;
#(
    parameter int unsigned FREQ_W = DEF_FREQ_W,
    parameter int unsigned PH_W   = DEF_PH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_vld,
    input  logic              freq_wr,
    input  logic [FREQ_W-1:0] freq_wdata,
    input  logic              ofs_wr,
    input  logic [PH_W-1:0]   ofs_wdata,
    input  logic              freq_strobe,
    input  logic              ofs_strobe,
    input  logic              sync_in,
    input  logic              sync_en,
    output logic [PH_W-1:0]   phase_out
);
    logic              sync_xfer;
    logic [FREQ_W-1:0] freq_hold, freq_act, acc;
    logic [PH_W-1:0]   ofs_hold, ofs_act;

    assign sync_xfer = sync_in & sync_en;

    dbuf_reg #(.W(FREQ_W)) u_freq_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (freq_wr),
        .wdata     (freq_wdata),
        .strobe    (freq_strobe),
        .sync_xfer (sync_xfer),
        .hold_q    (freq_hold),
        .act_q     (freq_act)
    );

    dbuf_reg #(.W(PH_W)) u_ofs_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (ofs_wr),
        .wdata     (ofs_wdata),
        .strobe    (ofs_strobe),
        .sync_xfer (sync_xfer),
        .hold_q    (ofs_hold),
        .act_q     (ofs_act)
    );

    phase_accum #(.W(FREQ_W)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (sample_vld),
        .step    (freq_act),
        .acc_q   (acc)
    );

    phase_sum #(.AW(FREQ_W), .PW(PH_W)) u_sum (
        .acc   (acc),
        .ofs   (ofs_act),
        .phase (phase_out)
    );
endmodule

// File: rtl/carrier_phase_chk.sv
module carrier_phase_chk #(
    parameter int unsigned FREQ_W = 32,
    parameter int unsigned PH_W   = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sample_vld,
    input logic              freq_strobe,
    input logic              ofs_strobe,
    input logic              sync_in,
    input logic              sync_en,
    input logic [FREQ_W-1:0] freq_hold,
    input logic [FREQ_W-1:0] freq_act,
    input logic [PH_W-1:0]   ofs_hold,
    input logic [PH_W-1:0]   ofs_act,
    input logic [FREQ_W-1:0] acc
);
    assert_freq_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!freq_strobe && !(sync_in && sync_en)) |=> $stable(freq_act));

    assert_freq_xfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        freq_strobe |=> (freq_act == $past(freq_hold)));

    assert_ofs_xfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ofs_strobe |=> (ofs_act == $past(ofs_hold)));

    assert_sync_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_in && sync_en) |=>
            (freq_act == $past(freq_hold) && ofs_act == $past(ofs_hold)));

    assert_sync_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_in && !sync_en && !ofs_strobe) |=> $stable(ofs_act));

    assert_acc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |=> $stable(acc));

    assert_acc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |=> (acc == FREQ_W'($past(acc) + $past(freq_act))));
endmodule

bind carrier_phase_gen carrier_phase_chk #(.FREQ_W(FREQ_W), .PH_W(PH_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_vld  (sample_vld),
    .freq_strobe (freq_strobe),
    .ofs_strobe  (ofs_strobe),
    .sync_in     (sync_in),
    .sync_en     (sync_en),
    .freq_hold   (freq_hold),
    .freq_act    (freq_act),
    .ofs_hold    (ofs_hold),
    .ofs_act     (ofs_act),
    .acc         (acc)
);

// File: tb/carrier_phase_gen_bench.sv
`timescale 1ns/1ps
module carrier_phase_gen_bench;
    localparam int FW = 32;
    localparam int PW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sample_vld = 0, freq_wr = 0, ofs_wr = 0;
    logic          freq_strobe = 0, ofs_strobe = 0, sync_in = 0, sync_en = 0;
    logic [FW-1:0] freq_wdata = '0;
    logic [PW-1:0] ofs_wdata = '0;
    logic [PW-1:0] phase_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // bench-side reference state
    logic [FW-1:0] m_fh = '0, m_fa = '0, m_acc = '0;
    logic [PW-1:0] m_oh = '0, m_oa = '0;

    always #4 clk = ~clk;

    carrier_phase_gen u_carrier_phase_gen (
        .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld),
        .freq_wr(freq_wr), .freq_wdata(freq_wdata),
        .ofs_wr(ofs_wr), .ofs_wdata(ofs_wdata),
        .freq_strobe(freq_strobe), .ofs_strobe(ofs_strobe),
        .sync_in(sync_in), .sync_en(sync_en), .phase_out(phase_out)
    );

    task automatic check(input string req, input logic [PW-1:0] exp);
        n_checks++;
        if (phase_out !== exp) begin
            n_fail++;
            $display("FAIL %s: phase_out=%0h expected=%0h", req, phase_out, exp);
        end
    endtask

    // drive one cycle, advance the reference per R2..R9, compare per R8
    task automatic step(input string req, input bit v, input bit fw, input logic [FW-1:0] fd,
                        input bit ow, input logic [PW-1:0] od, input bit fs, input bit os,
                        input bit si, input bit se);
        logic sx;
        sample_vld = v; freq_wr = fw; freq_wdata = fd; ofs_wr = ow; ofs_wdata = od;
        freq_strobe = fs; ofs_strobe = os; sync_in = si; sync_en = se;
        @(posedge clk);
        sx = si & se;
        if (v) m_acc = m_acc + m_fa;
        if (fs || sx) m_fa = m_fh;
        if (os || sx) m_oa = m_oh;
        if (fw) m_fh = fd;
        if (ow) m_oh = od;
        @(negedge clk);
        check(req, m_acc[FW-1 -: PW] + m_oa);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: expired, expected completion");
        if (!done) $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", '0);

        // R2: holding write alone changes nothing
        step("R2", 1, 1, 32'h0100_0000, 0, '0, 0, 0, 0, 0);
        step("R2", 1, 0, '0, 0, '0, 0, 0, 0, 0);
        // R3: strobe, new step from the next sample on
        step("R3", 1, 0, '0, 0, '0, 1, 0, 0, 0);
        for (int i = 0; i < 4; i++) step("R3", 1, 0, '0, 0, '0, 0, 0, 0, 0);
        // R4: offset strobe
        step("R4", 0, 0, '0, 1, 10'h3F0, 0, 0, 0, 0);
        step("R4", 0, 0, '0, 0, '0, 0, 1, 0, 0);
        // R6: sync without enable ignored
        step("R6", 1, 1, 32'h8000_0000, 1, 10'h155, 0, 0, 0, 0);
        step("R6", 1, 0, '0, 0, '0, 0, 0, 1, 0);
        step("R6", 1, 0, '0, 0, '0, 0, 0, 0, 0);
        // R5: sync with enable moves both
        step("R5", 1, 0, '0, 0, '0, 0, 0, 1, 1);
        for (int i = 0; i < 4; i++) step("R7", 1, 0, '0, 0, '0, 0, 0, 0, 0);
        // R7: hold without samples, wrap with all-ones step
        step("R7", 0, 1, 32'hFFFF_FFFF, 0, '0, 1, 0, 0, 0);
        for (int i = 0; i < 3; i++) step("R7", 0, 0, '0, 0, '0, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) step("R7", 1, 0, '0, 0, '0, 1, 0, 0, 0);
        // R9: write and transfer at the same edge
        step("R9", 1, 1, 32'h0040_0000, 1, 10'h2AA, 1, 1, 0, 0);
        step("R9", 1, 1, 32'h1234_5678, 1, 10'h011, 0, 0, 1, 1);
        step("R9", 1, 0, '0, 0, '0, 0, 0, 0, 0);
        // R8: sweep of all control combinations with fresh data
        for (int r = 0; r < 60; r++)
            for (int c = 0; c < 128; c++)
                step("R8", c[0], c[1], $urandom, c[2], PW'($urandom), c[3], c[4], c[5], c[6]);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule